// File: doc/BRIEF.md
# Data Burst Length Monitor

This block watches a word stream in which every accepted word is marked either as a control word or as a data word. A burst is the run of data words that lies between two control words. The monitor counts the data words of each burst and, when the control word that closes the burst is accepted, compares the count against two thresholds that are supplied as inputs. The upper threshold gives the largest burst that is allowed. The lower threshold gives the smallest burst that is expected.

A burst longer than the upper threshold produces a long-burst error pulse. A burst shorter than the lower threshold produces a short-burst indication pulse. The short indication is withheld when the closing control word carries an end-of-packet mark, because a packet tail is allowed to be short. Both results are one-clock status pulses. They are registered, so each appears on the clock after the closing control word. The monitor only observes the stream and never stalls or changes it. It is placed beside a transmit scheduler or a receive framer to show poor burst scheduling.

Top module: `burst_len_monitor`

## Requirements
- R1: When `rst_n` is low, the counter, the burst-open state and both outputs are cleared. After reset, the first accepted control word only opens a burst and never raises a flag, even if data words came before it.
- R2: A data word is counted only in a cycle where `word_vld` is 1 and `word_is_ctrl` is 0. Cycles with `word_vld` at 0 leave the count unchanged.
- R3: When a control word (`word_vld`=1, `word_is_ctrl`=1) closes an open burst of N data words with N > `max_len`, `long_err` is 1 on the next clock. N equal to `max_len` raises no error. The value of `ctrl_eop` does not affect this flag.
- R4: When a control word with `ctrl_eop`=0 closes an open burst with 0 < N < `min_len`, `short_ind` is 1 on the next clock. N equal to `min_len` raises no indication.
- R5: When the closing control word has `ctrl_eop`=1, `short_ind` stays 0 whatever the value of N.
- R6: A burst of zero data words, formed by two control words with no data word between them (idle cycles allowed), raises neither flag.
- R7: Each flag is high for exactly the one clock that follows the closing control word. A flag is never high in a cycle that does not follow an accepted control word. The thresholds are sampled on the cycle the closing control word is accepted.
- R8: The data-word count saturates at 2^CNT_W-1 and does not wrap. A burst longer than that is judged as having exactly 2^CNT_W-1 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| word_vld | input | 1 | A word is present this cycle |
| word_is_ctrl | input | 1 | 1 = control word, 0 = data word |
| ctrl_eop | input | 1 | End-of-packet mark; meaningful on control words only |
| max_len | input | CNT_W | Largest allowed burst, in data words |
| min_len | input | CNT_W | Smallest expected burst, in data words |
| long_err | output | 1 | One-clock pulse: the burst just closed was too long |
| short_ind | output | 1 | One-clock pulse: the burst just closed was too short and did not end a packet |

## Verification
Both results are due exactly one clock after the rising edge at which the closing control word is sampled. Data words and idle cycles must never produce a pulse in the following clock. The bench drives inputs on falling edges. On each rising edge its reference model works out what the registered outputs must show after that edge. It then compares the outputs with that prediction on the next falling edge, so every cycle is checked, including the quiet cycles around each pulse. The saturation case runs a burst longer than the counter's range, so that a counter that wraps would give the opposite verdicts.

// File: rtl/burst_mon_pkg.sv
// Package: shared types for the burst length monitor.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package burst_mon_pkg;

    // Default width of the burst counter and of both thresholds.
    localparam int unsigned DEF_CNT_W = 16;

    // Result of judging one closed burst.
    typedef struct packed {
        logic too_long;
        logic too_short;
    } verdict_t;

endpackage

// File: rtl/burst_run_counter.sv
// Module: burst_run_counter
// Counts the accepted data words of the burst that is currently open.
// The count saturates at all-ones, and an accepted control word clears it.
// Also records whether any control word has been seen since reset,
// which means a burst is open.
// Assumes: synchronous active-low reset; word_is_ctrl is meaningful only
// when word_vld is 1.
module burst_run_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_vld,
    input  logic             word_is_ctrl,
    output logic [CNT_W-1:0] run_cnt,
    output logic             burst_open
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic take_ctrl;
    logic take_data;

    // Decode what kind of word is accepted this cycle.
    always_comb begin
        take_ctrl = word_vld & word_is_ctrl;
        take_data = word_vld & ~word_is_ctrl;
    end

    // Saturating data-word counter, cleared by each control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (take_ctrl) begin
            run_cnt <= '0;
        end else if (take_data && (run_cnt != CNT_TOP)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // The first control word after reset opens the first burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_open <= 1'b0;
        end else if (take_ctrl) begin
            burst_open <= 1'b1;
        end
    end

endmodule

// File: rtl/burst_judge.sv
// Module: burst_judge
// Purely combinational. Judges a burst at the cycle its closing control
// word is accepted and compares the count against both thresholds.
// Assumes: run_cnt holds the data words counted so far (not including
// the current word), and burst_open is 0 until a control word is seen.
module burst_judge
    import burst_mon_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             word_vld,
    input  logic             word_is_ctrl,
    input  logic             ctrl_eop,
    input  logic [CNT_W-1:0] run_cnt,
    input  logic             burst_open,
    input  logic [CNT_W-1:0] max_len,
    input  logic [CNT_W-1:0] min_len,
    output verdict_t         verdict
);
    logic closing;
    logic nonzero;

    // A burst is closed only by an accepted control word while one is open.
    always_comb begin
        closing = word_vld & word_is_ctrl & burst_open;
        nonzero = (run_cnt != '0);
    end

    // Compare against the thresholds; end-of-packet suppresses the short flag.
    always_comb begin
        verdict.too_long  = closing & (run_cnt > max_len);
        verdict.too_short = closing & nonzero & (run_cnt < min_len) & ~ctrl_eop;
    end

endmodule

// File: rtl/burst_flag_reg.sv
// Module: burst_flag_reg
// Registers the verdict so that each flag is a clean one-clock pulse
// on the clock after the closing control word.
// Assumes: the verdict is valid in a single cycle only.
module burst_flag_reg
    import burst_mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_t verdict,
    output logic     long_err,
    output logic     short_ind
);
    // Capture the verdict each cycle; reset forces both flags low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            long_err  <= 1'b0;
            short_ind <= 1'b0;
        end else begin
            long_err  <= verdict.too_long;
            short_ind <= verdict.too_short;
        end
    end

endmodule

// File: rtl/burst_len_monitor.sv
// Module: burst_len_monitor (top)
// Observes a tagged word stream and pulses status flags for data bursts
// that are too long or too short. It never stalls or alters the stream.
// Assumes: synchronous active-low reset; thresholds are stable while the
// closing control word is presented.
module burst_len_monitor
    import burst_mon_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_vld,
    input  logic             word_is_ctrl,
    input  logic             ctrl_eop,
    input  logic [CNT_W-1:0] max_len,
    input  logic [CNT_W-1:0] min_len,
    output logic             long_err,
    output logic             short_ind
);
    logic [CNT_W-1:0] run_cnt;
    logic             burst_open;
    verdict_t         verdict;

    burst_run_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_vld     (word_vld),
        .word_is_ctrl (word_is_ctrl),
        .run_cnt      (run_cnt),
        .burst_open   (burst_open)
    );

    burst_judge #(.CNT_W(CNT_W)) u_judge (
        .word_vld     (word_vld),
        .word_is_ctrl (word_is_ctrl),
        .ctrl_eop     (ctrl_eop),
        .run_cnt      (run_cnt),
        .burst_open   (burst_open),
        .max_len      (max_len),
        .min_len      (min_len),
        .verdict      (verdict)
    );

    burst_flag_reg u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .verdict   (verdict),
        .long_err  (long_err),
        .short_ind (short_ind)
    );

endmodule

// File: rtl/burst_len_monitor_chk.sv
// Module: burst_len_monitor_chk
// Checker for burst_len_monitor. It sees only the ports of the top module
// and relates the flags to the words accepted on the previous clock.
// Assumes: synchronous active-low reset; flags are registered one clock.
module burst_len_monitor_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_vld,
    input logic             word_is_ctrl,
    input logic             ctrl_eop,
    input logic [CNT_W-1:0] max_len,
    input logic [CNT_W-1:0] min_len,
    input logic             long_err,
    input logic             short_ind
);
    AST_FLAG_AFTER_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (long_err || short_ind) |-> $past(word_vld && word_is_ctrl)); // R7

    AST_EOP_HIDES_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        short_ind |-> !$past(ctrl_eop)); // R5

    AST_LONG_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (long_err && !(word_vld && word_is_ctrl)) |=> !long_err); // R7

    AST_SHORT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (short_ind && !(word_vld && word_is_ctrl)) |=> !short_ind); // R7

    AST_ZERO_BURST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(word_vld && word_is_ctrl) && $past(word_vld && word_is_ctrl, 2))
        |-> (!long_err && !short_ind)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(word_vld) |-> (!long_err && !short_ind)); // R2

endmodule

bind burst_len_monitor burst_len_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_vld     (word_vld),
    .word_is_ctrl (word_is_ctrl),
    .ctrl_eop     (ctrl_eop),
    .max_len      (max_len),
    .min_len      (min_len),
    .long_err     (long_err),
    .short_ind    (short_ind)
);

// File: tb/sim_burst_len_monitor.sv
// Bench for burst_len_monitor: a behavioural reference model predicts
// both flags on every rising edge, and the bench compares them on the
// following falling edge.
module sim_burst_len_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int CNT_TOP    = (1 << CNT_W) - 1;
    localparam int WATCHDOG   = 190000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             word_vld = 1'b0;
    logic             word_is_ctrl = 1'b0;
    logic             ctrl_eop = 1'b0;
    logic [CNT_W-1:0] max_len = '0;
    logic [CNT_W-1:0] min_len = '0;
    logic             long_err;
    logic             short_ind;

    int    n_vec = 0;
    int    n_bad = 0;
    int    n_cyc = 0;
    bit    started = 0;
    bit    exp_long = 0;
    bit    exp_short = 0;
    bit    m_open = 0;
    int    m_cnt = 0;
    string cur_req = "R1";

    burst_len_monitor #(.CNT_W(CNT_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_vld     (word_vld),
        .word_is_ctrl (word_is_ctrl),
        .ctrl_eop     (ctrl_eop),
        .max_len      (max_len),
        .min_len      (min_len),
        .long_err     (long_err),
        .short_ind    (short_ind)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: a plain integer count and a flag for "burst open".
    always @(posedge clk) begin
        int judged;
        started = 1;
        if (!rst_n) begin
            exp_long = 0; exp_short = 0; m_open = 0; m_cnt = 0;
        end else begin
            exp_long = 0; exp_short = 0;
            if (word_vld && word_is_ctrl) begin
                if (m_open) begin
                    judged = (m_cnt > CNT_TOP) ? CNT_TOP : m_cnt;
                    exp_long  = judged > int'(max_len);
                    exp_short = (judged != 0) && (judged < int'(min_len)) && !ctrl_eop;
                end
                m_open = 1; m_cnt = 0;
            end else if (word_vld) begin
                m_cnt++;
            end
        end
    end

    // Compare the outputs on every falling edge; the watchdog ends a hung run.
    always @(negedge clk) begin
        if (started) begin
            n_vec++;
            if (long_err !== exp_long || short_ind !== exp_short) begin
                n_bad++;
                $display("FAIL %s cycle %0d: long_err=%b expected %b, short_ind=%b expected %b",
                         cur_req, n_cyc, long_err, exp_long, short_ind, exp_short);
            end
        end
        n_cyc++;
        if (n_cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d, expected at most %0d", n_cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            word_vld = 0; word_is_ctrl = 0; ctrl_eop = 0;
        end
    endtask

    task automatic data(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            word_vld = 1; word_is_ctrl = 0; ctrl_eop = 0;
        end
    endtask

    task automatic ctrl(input bit eop);
        @(negedge clk);
        word_vld = 1; word_is_ctrl = 1; ctrl_eop = eop;
    endtask

    initial begin
        max_len = 8; min_len = 4;
        // r1_: reset holds flags low; data before first control is ignored
        idle(3);
        @(negedge clk); rst_n = 1;
        data(2); ctrl(0); idle(2);
        // r4_ and r5_: short bursts with and without end-of-packet
        cur_req = "R4"; data(2); ctrl(0); idle(1);
        data(3); ctrl(0); data(4); ctrl(0); idle(1);
        cur_req = "R5"; data(2); ctrl(1); data(1); ctrl(1); idle(1);
        // r3_: long bursts and the equal boundary, eop has no effect on long
        cur_req = "R3"; data(9); ctrl(0); data(8); ctrl(0); data(12); ctrl(1); idle(2);
        // r2_: idle cycles between data words are not counted
        cur_req = "R2";
        data(1); idle(3); data(1); idle(2); data(1); ctrl(0); idle(1);
        for (int k = 0; k < 9; k++) begin data(1); idle(1); end
        ctrl(0); idle(1);
        // r6_: zero-length bursts, back to back and across idles
        cur_req = "R6"; ctrl(0); ctrl(0); ctrl(0); idle(3); ctrl(0); idle(1);
        // r7_: thresholds sampled at the closing word, consecutive closes
        cur_req = "R7";
        data(5); @(negedge clk); max_len = 3; min_len = 10;
        word_vld = 1; word_is_ctrl = 1; ctrl_eop = 0;
        data(2); ctrl(0); data(20); ctrl(0); ctrl(0); idle(2);
        max_len = 8; min_len = 4;
        // r1_: a reset in mid-burst discards the burst and reopens nothing
        cur_req = "R1"; data(3); @(negedge clk); rst_n = 0; word_vld = 0;
        idle(2); @(negedge clk); rst_n = 1;
        data(1); ctrl(0); data(20); ctrl(0); idle(2);
        // r8_: a burst beyond the counter range saturates rather than wraps
        cur_req = "R8"; max_len = CNT_W'(CNT_TOP - 1); min_len = CNT_W'(CNT_TOP);
        data(CNT_TOP + 4500); ctrl(0); idle(2);
        max_len = CNT_W'(CNT_TOP); min_len = 0;
        data(CNT_TOP + 10); ctrl(0); idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule